// File: doc/BRIEF.md
# Parallel Row Elimination Unit for LU Factorisation

This block carries out one elimination step of an LU factorisation on a single block of K columns of one matrix row. It receives the block of the row being reduced, the matching block of the pivot row, the element of the reduced row that sits in the pivot column, the pivot itself, and three indices: the pivot index, the row index and the first column of the block. It returns the reduced block and the elimination multiplier. The multiplier is the value that later stands in the lower triangular factor.

All data are signed 16-bit fixed point with 8 fraction bits. The multiplier comes from a sequential restoring divider, one quotient bit per cycle. K lanes then apply the multiply-subtract in a single cycle. Pivot-row lanes at or left of the pivot column are masked to zero, so the update only touches columns to the right of the pivot. The multiplier is also written into the lane that holds the pivot column. A controller that walks the loop indices presents one block at a time with a valid strobe and collects the result when the output strobe rises.

Top module: `lu_row_elim`

## Requirements
- R1: A request is taken when `in_valid_i` is high while `busy_o` is low. `busy_o` is high from the cycle after acceptance until the result appears. A request presented while `busy_o` is high is dropped: it produces no result and does not change the result in flight.
- R2: For j not equal to i, `mult_o` equals the truncated quotient floor(|A[j,i]|*256/|A[i,i]|), with the sign of the quotient applied. The result clamps to 0x7FFF when positive and to 0x8000 when negative whenever it does not fit.
- R3: A zero pivot with j not equal to i raises `div_zero_o` together with the result. In that case `mult_o` is 0x8000 if A[j,i] is negative and 0x7FFF otherwise. A nonzero pivot leaves `div_zero_o` low.
- R4: Lane l of the row ports (bits 16*l+15 down to 16*l) holds column `blk_k_i`+l. For a column greater than i, the lane output is A[j,c] - r, saturated. Here r = floor((m*A[i,c] + 128) / 256) and m is the multiplier.
- R5: Lanes whose column is less than i leave the row value unchanged.
- R6: When j is not equal to i, the lane whose column equals i outputs the multiplier.
- R7: A lane result above 32767 becomes 0x7FFF, and one below -32768 becomes 0x8000.
- R8: When j equals i, the row block passes through unchanged, `mult_o` is 0x0100 (1.0), `div_zero_o` is low, and the result appears one cycle after acceptance.
- R9: For j not equal to i, `out_valid_o` rises 25 cycles after the acceptance edge. `out_valid_o` is always a single-cycle pulse.
- R10: After reset, `out_valid_o`, `busy_o`, `div_zero_o`, `mult_o` and `row_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| row_i | input | K*16 | Block of the row being reduced, lane l in bits 16l+15:16l |
| piv_row_i | input | K*16 | Matching block of the pivot row |
| a_ji_i | input | 16 | Element of the reduced row in the pivot column |
| a_ii_i | input | 16 | Pivot element |
| idx_i_i | input | IDX_W | Pivot index i |
| idx_j_i | input | IDX_W | Row index j |
| blk_k_i | input | IDX_W | Column of lane 0 |
| busy_o | output | 1 | Request in progress |
| out_valid_o | output | 1 | Result strobe, one cycle |
| row_o | output | K*16 | Updated row block |
| mult_o | output | 16 | Multiplier m |
| div_zero_o | output | 1 | Pivot was zero |

## Verification
The assertions check properties that hold on every cycle. They confirm that the result strobe is a one-cycle pulse, that captured operands stay frozen while a request is dropped during busy, and that left-of-pivot lanes match the captured input. They also confirm that the pivot-column lane carries the multiplier, that the diagonal case returns 1.0, and that the zero-pivot quotient takes one of its two clamp values. The arithmetic itself can only be shown by the bench's scenarios. These cover the rounded products, the truncated and clamped quotients and the saturated differences over swept pivot, row and block indices. They also cover the exact latency of both paths.

// File: rtl/lu_elim_pkg.sv
package lu_elim_pkg;
  localparam int Q_W    = 16;
  localparam int Q_FRAC = 8;
  localparam int Q_MAX  = 2**(Q_W-1) - 1;
  localparam int Q_MIN  = -(2**(Q_W-1));
  localparam logic [Q_W-1:0] Q_ONE = Q_W'(1 << Q_FRAC);

  typedef logic signed [Q_W-1:0] q_t;
  typedef logic signed [2*Q_W+1:0] q_wide_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_DIAG} elim_st_e;

  function automatic q_t q_sat(input q_wide_t v);
    if (v > Q_MAX)      return q_t'(Q_MAX);
    else if (v < Q_MIN) return q_t'(Q_MIN);
    else                return v[Q_W-1:0];
  endfunction
endpackage

// File: rtl/lu_fx_div.sv
module lu_fx_div
  import lu_elim_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  q_t   num_i,
  input  q_t   den_i,
  output logic done_o,
  output q_t   quo_o,
  output logic zero_o
);
  localparam int NW = Q_W + Q_FRAC;
  localparam int CW = $clog2(NW + 1);
  localparam logic [NW-1:0] POS_LIM = NW'(Q_MAX);
  localparam logic [NW-1:0] NEG_LIM = NW'(Q_MAX) + NW'(1);

  logic          run_q, done_q, neg_q, zero_q;
  logic [CW-1:0] cnt_q;
  logic [NW-1:0] dvd_q;
  logic [Q_W-1:0] rem_q, dmag_q;
  logic [Q_W-1:0] num_mag, den_mag;
  logic [Q_W:0]   trial, rem_nx;
  logic           ge;

  assign num_mag = num_i[Q_W-1] ? (~num_i + 1'b1) : num_i;
  assign den_mag = den_i[Q_W-1] ? (~den_i + 1'b1) : den_i;

  assign trial  = {rem_q, dvd_q[NW-1]};
  assign ge     = trial >= {1'b0, dmag_q};
  assign rem_nx = ge ? (trial - {1'b0, dmag_q}) : trial;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
      cnt_q  <= '0;
      dvd_q  <= '0;
      rem_q  <= '0;
      dmag_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        run_q  <= 1'b1;
        cnt_q  <= '0;
        dvd_q  <= {num_mag, {Q_FRAC{1'b0}}};
        rem_q  <= '0;
        dmag_q <= den_mag;
        neg_q  <= num_i[Q_W-1] ^ den_i[Q_W-1];
        zero_q <= (den_i == '0);
      end else if (run_q) begin
        rem_q <= rem_nx[Q_W-1:0];
        dvd_q <= {dvd_q[NW-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NW-1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // divide by zero yields an all-ones quotient, which clamps by sign
  always_comb begin
    if (neg_q) quo_o = (dvd_q > NEG_LIM) ? q_t'(Q_MIN) : q_t'(~dvd_q[Q_W-1:0] + 1'b1);
    else       quo_o = (dvd_q > POS_LIM) ? q_t'(Q_MAX) : q_t'(dvd_q[Q_W-1:0]);
  end

  assign done_o = done_q;
  assign zero_o = zero_q;

  // R2
  div_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q < CW'(NW));
  // R9
  div_done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !run_q);
endmodule

// File: rtl/lu_elim_lane.sv
module lu_elim_lane
  import lu_elim_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  q_t               a_i,
  input  q_t               p_i,
  input  q_t               m_i,
  input  logic [IDX_W:0]   col_i,
  input  logic [IDX_W-1:0] piv_i,
  output q_t               res_o
);
  localparam logic signed [2*Q_W:0] HALF = (2*Q_W+1)'(1 << (Q_FRAC-1));

  q_t                      p_eff;
  logic signed [2*Q_W-1:0] prod;
  logic signed [2*Q_W:0]   rnd_pre, rnd;
  q_wide_t                 diff;

  assign p_eff   = (col_i > {1'b0, piv_i}) ? p_i : '0;
  assign prod    = m_i * p_eff;
  assign rnd_pre = $signed({prod[2*Q_W-1], prod}) + HALF;
  assign rnd     = rnd_pre >>> Q_FRAC;
  assign diff    = $signed({{(Q_W+2){a_i[Q_W-1]}}, a_i}) - $signed({rnd[2*Q_W], rnd});
  assign res_o   = (col_i == {1'b0, piv_i}) ? m_i : q_sat(diff);
endmodule

// File: rtl/lu_row_elim.sv
module lu_row_elim
  import lu_elim_pkg::*;
#(
  parameter int K     = 8,
  parameter int IDX_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [K*Q_W-1:0]   row_i,
  input  logic [K*Q_W-1:0]   piv_row_i,
  input  logic [Q_W-1:0]     a_ji_i,
  input  logic [Q_W-1:0]     a_ii_i,
  input  logic [IDX_W-1:0]   idx_i_i,
  input  logic [IDX_W-1:0]   idx_j_i,
  input  logic [IDX_W-1:0]   blk_k_i,
  output logic               busy_o,
  output logic               out_valid_o,
  output logic [K*Q_W-1:0]   row_o,
  output logic [Q_W-1:0]     mult_o,
  output logic               div_zero_o
);
  localparam int RW = K * Q_W;

  elim_st_e         st_q;
  logic [RW-1:0]    row_q, piv_q, lane_res;
  logic [IDX_W-1:0] i_q, j_q, k_q;
  logic             accept, div_start, div_done, div_zero;
  q_t               div_quo;
  logic [IDX_W:0]   lane_col [K];

  assign busy_o    = (st_q != ST_IDLE);
  assign accept    = in_valid_i && !busy_o;
  assign div_start = accept && (idx_i_i != idx_j_i);

  lu_fx_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (q_t'(a_ji_i)),
    .den_i  (q_t'(a_ii_i)),
    .done_o (div_done),
    .quo_o  (div_quo),
    .zero_o (div_zero)
  );

  for (genvar l = 0; l < K; l++) begin : g_lane
    assign lane_col[l] = {1'b0, k_q} + (IDX_W+1)'(l);
    lu_elim_lane #(.IDX_W(IDX_W)) u_lane (
      .a_i  (q_t'(row_q[l*Q_W +: Q_W])),
      .p_i  (q_t'(piv_q[l*Q_W +: Q_W])),
      .m_i  (div_quo),
      .col_i(lane_col[l]),
      .piv_i(i_q),
      .res_o(lane_res[l*Q_W +: Q_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      row_q       <= '0;
      piv_q       <= '0;
      i_q         <= '0;
      j_q         <= '0;
      k_q         <= '0;
      out_valid_o <= 1'b0;
      row_o       <= '0;
      mult_o      <= '0;
      div_zero_o  <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          row_q <= row_i;
          piv_q <= piv_row_i;
          i_q   <= idx_i_i;
          j_q   <= idx_j_i;
          k_q   <= blk_k_i;
          st_q  <= (idx_i_i == idx_j_i) ? ST_DIAG : ST_DIV;
        end
        ST_DIAG: begin
          row_o       <= row_q;
          mult_o      <= Q_ONE;
          div_zero_o  <= 1'b0;
          out_valid_o <= 1'b1;
          st_q        <= ST_IDLE;
        end
        ST_DIV: if (div_done) begin
          row_o       <= lane_res;
          mult_o      <= div_quo;
          div_zero_o  <= div_zero;
          out_valid_o <= 1'b1;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  out_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  // R1
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && in_valid_i) |=> $stable(row_q) && $stable(i_q));
  // R3
  zero_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && div_zero_o) |-> (mult_o == 16'h7FFF || mult_o == 16'h8000));
  // R8
  diag_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && i_q == j_q) |-> (mult_o == Q_ONE && !div_zero_o && row_o == row_q));

  for (genvar l = 0; l < K; l++) begin : g_lane_chk
    // R5
    left_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && lane_col[l] < {1'b0, i_q}) |-> row_o[l*Q_W +: Q_W] == row_q[l*Q_W +: Q_W]);
    // R6
    piv_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && i_q != j_q && lane_col[l] == {1'b0, i_q}) |-> row_o[l*Q_W +: Q_W] == mult_o);
  end
endmodule

// File: tb/tb_lu_row_elim.sv
module tb_lu_row_elim;
  localparam int K = 4;
  localparam int IDX_W = 8;
  localparam int LAT = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [K*16-1:0] row_i = '0, piv_i = '0;
  logic [15:0] aji = '0, aii = '0;
  logic [IDX_W-1:0] ii = '0, jj = '0, kk = '0;
  logic busy, out_valid, dz;
  logic [K*16-1:0] row_o;
  logic [15:0] mult;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  lu_row_elim #(.K(K), .IDX_W(IDX_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .row_i(row_i), .piv_row_i(piv_i), .a_ji_i(aji), .a_ii_i(aii),
    .idx_i_i(ii), .idx_j_i(jj), .blk_k_i(kk),
    .busy_o(busy), .out_valid_o(out_valid), .row_o(row_o),
    .mult_o(mult), .div_zero_o(dz));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int ref_mult(input int a, input int b);
    int mag, neg;
    if (b == 0) return (a < 0) ? -32768 : 32767;
    neg = (a < 0) != (b < 0);
    mag = ((a < 0 ? -a : a) * 256) / (b < 0 ? -b : b);
    if (neg) return (mag > 32768) ? -32768 : -mag;
    return (mag > 32767) ? 32767 : mag;
  endfunction

  task automatic run(input logic [K*16-1:0] r, input logic [K*16-1:0] p,
                     input int a, input int b, input int i, input int j, input int k,
                     input bit inject);
    int lat = 0, m, exp_lat;
    @(negedge clk);
    row_i = r; piv_i = p; aji = 16'(a); aii = 16'(b);
    ii = IDX_W'(i); jj = IDX_W'(j); kk = IDX_W'(k); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(busy === 1'b1, "R1", "busy after accept", int'(busy), 1);
    while (lat < 60) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (out_valid) break;
      in_valid = 1'b0;
      if (inject && lat == 3) begin
        in_valid = 1'b1; row_i = ~r; piv_i = ~p; aji = 16'(b); aii = 16'(a);
        ii = IDX_W'(j); jj = IDX_W'(i + 3);
      end
    end
    in_valid = 1'b0;
    exp_lat = (i == j) ? 1 : LAT;
    chk(lat == exp_lat, (i == j) ? "R8" : "R9", "latency", lat, exp_lat);
    if (i == j) begin
      chk(mult == 16'h0100, "R8", "diag mult", int'(mult), 256);
      chk(dz == 1'b0, "R8", "diag zero flag", int'(dz), 0);
      chk(row_o == r, "R8", "diag row", int'(row_o[15:0]), int'(r[15:0]));
    end else begin
      m = ref_mult(a, b);
      chk($signed(mult) == m, "R2", "mult", int'($signed(mult)), m);
      chk(dz == (b == 0), "R3", "zero flag", int'(dz), int'(b == 0));
      for (int l = 0; l < K; l++) begin
        int c = k + l, av = int'($signed(r[l*16 +: 16])), pv = int'($signed(p[l*16 +: 16]));
        int got = int'($signed(row_o[l*16 +: 16])), e;
        string tag;
        if (c < i) begin e = av; tag = "R5"; end
        else if (c == i) begin e = m; tag = "R6"; end
        else begin
          int raw = av - ((m * pv + 128) >>> 8);
          e = sat16(raw);
          tag = (raw != e) ? "R7" : "R4";
        end
        chk(got == e, tag, $sformatf("lane %0d", l), got, e);
      end
    end
    if (inject) begin
      int extra = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (out_valid) extra++;
      end
      chk(extra == 0, "R1", "dropped request result", extra, 0);
    end
  endtask

  function automatic logic [K*16-1:0] rnd_blk();
    logic [K*16-1:0] v;
    for (int l = 0; l < K; l++) v[l*16 +: 16] = 16'($urandom);
    return v;
  endfunction

  initial begin
    #(5.0 * 150000);
    errs++; checks++;
    $display("FAIL R9 watchdog act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk(out_valid == 0 && busy == 0 && dz == 0, "R10", "reset strobes", int'({out_valid, busy, dz}), 0);
    chk(mult == 0 && row_o == 0, "R10", "reset data", int'(mult), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++)
      for (int kb = 0; kb < 8; kb += 4)
        for (int j = i; j < i + 3; j++) begin
          int b = int'($signed(16'($urandom)));
          if (b == 0) b = 1;
          if ((j & 1) == 0) b = (b % 2048) + ((b < 0) ? -128 : 128);
          run(rnd_blk(), rnd_blk(), int'($signed(16'($urandom % 4096))) - 2048, b, i, j, kb, 1'b0);
        end

    // R3 zero pivot, both signs and zero numerator
    run(rnd_blk(), rnd_blk(), 16'sh0300, 0, 1, 2, 0, 1'b0);
    run(rnd_blk(), rnd_blk(), -768, 0, 1, 2, 0, 1'b0);
    run(rnd_blk(), rnd_blk(), 0, 0, 2, 3, 0, 1'b0);
    // R2 quotient clamp positive and negative, exact negative limit
    run(rnd_blk(), rnd_blk(), 28672, 16, 0, 1, 0, 1'b0);
    run(rnd_blk(), rnd_blk(), 28672, -16, 0, 1, 0, 1'b0);
    run(rnd_blk(), rnd_blk(), -32768, 256, 0, 1, 0, 1'b0);
    run(rnd_blk(), rnd_blk(), 300, -1, 0, 1, 0, 1'b0);
    // R7 difference saturation high and low
    run({K{16'h7F00}}, {K{16'h8100}}, 1024, 256, 0, 1, 0, 1'b0);
    run({K{16'h8100}}, {K{16'h7F00}}, 1024, 256, 0, 1, 0, 1'b0);
    // R4 rounding at half-way points
    run({K{16'h0000}}, {K{16'h0001}}, 128, 256, 0, 1, 0, 1'b0);
    run({K{16'h0000}}, {K{16'hFFFF}}, 128, 256, 0, 1, 0, 1'b0);
    // R5 whole block left of pivot
    run(rnd_blk(), rnd_blk(), 500, 700, 7, 9, 0, 1'b0);
    // R8 diagonal with zero pivot
    run(rnd_blk(), rnd_blk(), 0, 0, 5, 5, 4, 1'b0);
    // R1 request during busy is dropped
    run(rnd_blk(), rnd_blk(), 1000, 3000, 2, 4, 0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule